// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller Core

This block keeps the interrupt state of one processor across 256 vectors. Three bit arrays hold it: pending requests, vectors in service, and the trigger mode of each vector. From these arrays and a task-priority value it computes a processor priority. It raises a pending line when the highest request outranks that priority. On an acknowledge it hands out the vector.

Each vector belongs to a priority class, which is the upper four bits of its number. A request is held back when its class does not exceed the class of the processor priority. The processor priority is the task priority or the class of the highest in-service vector, whichever ranks higher. An acknowledge that finds only held-back requests returns a programmable spurious vector and changes no state. An end-of-interrupt retires the highest in-service vector. If that vector was level-triggered and directed mode is off, the block emits a broadcast pulse that carries the vector, so the level source can be re-armed. Register decoding, timers and destination routing sit outside the block.

Top module: `vic_core`

## Requirements
- R1: A synchronous reset clears all three arrays, sets the task priority to 0 and the spurious register to 0x0FF (disabled). Right after reset, irq_pending is 0 and ppr_out is 0.
- R2: A request strobe sets the request bit of req_vector. When the controller is enabled and the request is deliverable, irq_pending is 1 in the cycle after the strobe.
- R3: Priority is by vector number: the highest-numbered request is the one acknowledged, and the highest-numbered in-service vector is the one retired.
- R4: ppr_out equals the task priority when tpr[7:4] is greater than or equal to the class of the highest in-service vector. Otherwise it equals that class in bits 7:4 with bits 3:0 zero. It is registered and reflects the state after the previous edge, so ppr_out is never below the task priority.
- R5: When ppr_out is nonzero and the highest request's class is at or below ppr_out[7:4], that request is masked. irq_pending stays 0, and an acknowledge returns the spurious register bits 7:0 without moving any bit.
- R6: ack_valid is answered one cycle later by ack_rsp_valid. With no request, ack_rsp_none is 1. With a deliverable request, ack_rsp_vector carries the vector, and the bit moves from the request array to the in-service array.
- R7: An end-of-interrupt clears the highest in-service bit. With none set it changes nothing.
- R8: If the retired vector's trigger bit is 1 and directed_eoi is 0, eoi_bcast pulses one cycle after the end-of-interrupt, with eoi_bcast_vector equal to that vector. An edge vector, or directed_eoi at 1, gives no pulse.
- R9: Each request overwrites the trigger bit of its vector: 1 for req_level=1, 0 for req_level=0. The most recent request decides whether a broadcast happens.
- R10: The spurious register is 9 bits wide. Bit 8 enables the controller and bits 7:0 are the spurious vector. While bit 8 is 0, irq_pending is 0 and acknowledges report ack_rsp_none.
- R11: Strobes in the same cycle are decided on the state at the start of the cycle. Retire happens first, then grant, then the new request is applied. A request arriving together with an acknowledge of its own vector therefore leaves the request bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level trigger, 0 = edge trigger |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 8 | New task priority |
| ack_valid | input | 1 | Acknowledge strobe |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| spur_we | input | 1 | Spurious register write strobe |
| spur_wdata | input | 9 | Bit 8 enable, bits 7:0 spurious vector |
| directed_eoi | input | 1 | Suppresses the broadcast when 1 |
| irq_pending | output | 1 | A deliverable request exists |
| ppr_out | output | 8 | Processor priority |
| ack_rsp_valid | output | 1 | Acknowledge answer valid |
| ack_rsp_none | output | 1 | Answer: no interrupt |
| ack_rsp_vector | output | 8 | Answer: granted or spurious vector |
| eoi_bcast | output | 1 | Broadcast pulse for a retired level vector |
| eoi_bcast_vector | output | 8 | Vector of the broadcast |

## Verification
The bench targets the equal-class boundary of the masking rule. A design that compares with "<" instead of "<=" would raise irq_pending for a request in the same class as the task priority. It also checks that a masked request stays blocked by a vector already in service, even when the task priority is zero. A design that ignored the in-service class would grant the lower vector instead of returning the spurious one. Other stimuli target overwriting the trigger bit, suppressing the broadcast in directed mode, and a request that coincides with an acknowledge of its own vector. Getting any of these wrong shows up as a lost request, a missing or extra broadcast pulse, or a wrong answer vector. A long random phase then compares every output on every cycle against a behavioural model.

// File: rtl/vic_pkg.sv
package vic_pkg;
    // width of the priority class taken from the top of a vector
    localparam int CLS_W = 4;

    typedef enum logic [1:0] {
        AK_IDLE  = 2'd0,
        AK_EMPTY = 2'd1,
        AK_SPUR  = 2'd2,
        AK_GRANT = 2'd3
    } ack_kind_e;
endpackage

// File: rtl/vic_highest.sv
module vic_highest #(
    parameter int N = 256,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] bits_i,
    output logic         found_o,
    output logic [W-1:0] idx_o
);
    // the last set bit seen in ascending order is the highest one
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < N; i++) begin
            if (bits_i[i]) begin
                found_o = 1'b1;
                idx_o   = W'(i);
            end
        end
    end
endmodule

// File: rtl/vic_prio.sv
module vic_prio
    import vic_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic [VEC_W-1:0] tpr_i,
    input  logic             svc_found_i,
    input  logic [VEC_W-1:0] svc_idx_i,
    input  logic             req_found_i,
    input  logic [VEC_W-1:0] req_idx_i,
    input  logic             en_i,
    output logic [VEC_W-1:0] ppr_o,
    output logic             deliver_o
);
    localparam int LOW_W = VEC_W - CLS_W;

    logic [CLS_W-1:0] svc_cls;
    logic [CLS_W-1:0] tpr_cls;
    logic [CLS_W-1:0] req_cls;
    logic             masked;

    always_comb begin
        svc_cls = svc_found_i ? svc_idx_i[VEC_W-1 -: CLS_W] : '0;
        tpr_cls = tpr_i[VEC_W-1 -: CLS_W];
        req_cls = req_idx_i[VEC_W-1 -: CLS_W];
        if (tpr_cls >= svc_cls) begin
            ppr_o = tpr_i;
        end else begin
            ppr_o = {svc_cls, {LOW_W{1'b0}}};
        end
        masked    = (ppr_o != '0) && (req_cls <= ppr_o[VEC_W-1 -: CLS_W]);
        deliver_o = en_i && req_found_i && !masked;
    end
endmodule

// File: rtl/vic_core.sv
module vic_core
    import vic_pkg::*;
#(
    parameter int NUM_VEC = 256
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic [$clog2(NUM_VEC)-1:0]   req_vector,
    input  logic                         req_level,
    input  logic                         tpr_we,
    input  logic [$clog2(NUM_VEC)-1:0]   tpr_wdata,
    input  logic                         ack_valid,
    input  logic                         eoi_valid,
    input  logic                         spur_we,
    input  logic [$clog2(NUM_VEC):0]     spur_wdata,
    input  logic                         directed_eoi,
    output logic                         irq_pending,
    output logic [$clog2(NUM_VEC)-1:0]   ppr_out,
    output logic                         ack_rsp_valid,
    output logic                         ack_rsp_none,
    output logic [$clog2(NUM_VEC)-1:0]   ack_rsp_vector,
    output logic                         eoi_bcast,
    output logic [$clog2(NUM_VEC)-1:0]   eoi_bcast_vector
);
    localparam int VEC_W  = $clog2(NUM_VEC);
    localparam int SPUR_W = VEC_W + 1;
    localparam logic [SPUR_W-1:0] SPUR_RST = {1'b0, {VEC_W{1'b1}}};

    typedef struct packed {
        logic [NUM_VEC-1:0] irr;
        logic [NUM_VEC-1:0] isr;
        logic [NUM_VEC-1:0] tmr;
        logic [VEC_W-1:0]   tpr;
        logic [SPUR_W-1:0]  spur;
        logic [VEC_W-1:0]   ppr;
        logic               pend;
        logic               rsp_v;
        logic               rsp_none;
        logic [VEC_W-1:0]   rsp_vec;
        logic               bc;
        logic [VEC_W-1:0]   bc_vec;
    } state_t;

    state_t st_q, st_d;

    // current-state view
    logic             spur_en;
    logic [VEC_W-1:0] tpr_cur;
    logic             cur_irr_found, cur_isr_found;
    logic [VEC_W-1:0] cur_irr_idx, cur_isr_idx;
    logic [VEC_W-1:0] ppr_cur;
    logic             cur_deliver;
    logic             cur_spur;
    ack_kind_e        ack_kind;

    // next-state view
    logic [NUM_VEC-1:0] irr_n, isr_n, tmr_n;
    logic [VEC_W-1:0]   tpr_n;
    logic [SPUR_W-1:0]  spur_n;
    logic               nxt_irr_found, nxt_isr_found;
    logic [VEC_W-1:0]   nxt_irr_idx, nxt_isr_idx;
    logic [VEC_W-1:0]   ppr_nxt;
    logic               nxt_deliver;

    assign spur_en = st_q.spur[SPUR_W-1];
    assign tpr_cur = st_q.tpr;

    vic_highest #(.N(NUM_VEC), .W(VEC_W)) u_cur_req (
        .bits_i(st_q.irr), .found_o(cur_irr_found), .idx_o(cur_irr_idx));
    vic_highest #(.N(NUM_VEC), .W(VEC_W)) u_cur_svc (
        .bits_i(st_q.isr), .found_o(cur_isr_found), .idx_o(cur_isr_idx));

    vic_prio #(.VEC_W(VEC_W)) u_cur_prio (
        .tpr_i(tpr_cur), .svc_found_i(cur_isr_found), .svc_idx_i(cur_isr_idx),
        .req_found_i(cur_irr_found), .req_idx_i(cur_irr_idx), .en_i(spur_en),
        .ppr_o(ppr_cur), .deliver_o(cur_deliver));

    // acknowledge outcome, decided on start-of-cycle state
    always_comb begin
        cur_spur = spur_en && cur_irr_found && !cur_deliver;
        if (!ack_valid) begin
            ack_kind = AK_IDLE;
        end else if (cur_deliver) begin
            ack_kind = AK_GRANT;
        end else if (cur_spur) begin
            ack_kind = AK_SPUR;
        end else begin
            ack_kind = AK_EMPTY;
        end
    end

    // bit moves: retire, then grant, then new request
    always_comb begin
        irr_n = st_q.irr;
        isr_n = st_q.isr;
        tmr_n = st_q.tmr;
        if (eoi_valid && cur_isr_found) begin
            isr_n[cur_isr_idx] = 1'b0;
        end
        if (ack_kind == AK_GRANT) begin
            irr_n[cur_irr_idx] = 1'b0;
            isr_n[cur_irr_idx] = 1'b1;
        end
        if (req_valid) begin
            irr_n[req_vector] = 1'b1;
            tmr_n[req_vector] = req_level;
        end
        tpr_n  = tpr_we  ? tpr_wdata  : st_q.tpr;
        spur_n = spur_we ? spur_wdata : st_q.spur;
    end

    vic_highest #(.N(NUM_VEC), .W(VEC_W)) u_nxt_req (
        .bits_i(irr_n), .found_o(nxt_irr_found), .idx_o(nxt_irr_idx));
    vic_highest #(.N(NUM_VEC), .W(VEC_W)) u_nxt_svc (
        .bits_i(isr_n), .found_o(nxt_isr_found), .idx_o(nxt_isr_idx));

    vic_prio #(.VEC_W(VEC_W)) u_nxt_prio (
        .tpr_i(tpr_n), .svc_found_i(nxt_isr_found), .svc_idx_i(nxt_isr_idx),
        .req_found_i(nxt_irr_found), .req_idx_i(nxt_irr_idx),
        .en_i(spur_n[SPUR_W-1]), .ppr_o(ppr_nxt), .deliver_o(nxt_deliver));

    always_comb begin
        st_d      = st_q;
        st_d.irr  = irr_n;
        st_d.isr  = isr_n;
        st_d.tmr  = tmr_n;
        st_d.tpr  = tpr_n;
        st_d.spur = spur_n;
        st_d.ppr  = ppr_nxt;
        st_d.pend = nxt_deliver;

        st_d.rsp_v    = (ack_kind != AK_IDLE);
        st_d.rsp_none = (ack_kind == AK_EMPTY);
        case (ack_kind)
            AK_GRANT: st_d.rsp_vec = cur_irr_idx;
            AK_SPUR:  st_d.rsp_vec = st_q.spur[VEC_W-1:0];
            default:  st_d.rsp_vec = '0;
        endcase

        st_d.bc     = eoi_valid && cur_isr_found && st_q.tmr[cur_isr_idx] && !directed_eoi;
        st_d.bc_vec = st_d.bc ? cur_isr_idx : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.spur <= SPUR_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_pending      = st_q.pend;
    assign ppr_out          = st_q.ppr;
    assign ack_rsp_valid    = st_q.rsp_v;
    assign ack_rsp_none     = st_q.rsp_none;
    assign ack_rsp_vector   = st_q.rsp_vec;
    assign eoi_bcast        = st_q.bc;
    assign eoi_bcast_vector = st_q.bc_vec;
endmodule

// File: rtl/vic_core_chk.sv
module vic_core_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             irq_pending,
    input logic [VEC_W-1:0] ppr_out,
    input logic [VEC_W-1:0] tpr_cur,
    input logic             spur_en,
    input logic             cur_irr_found,
    input logic             ack_valid,
    input logic             ack_rsp_valid,
    input logic             eoi_valid,
    input logic             directed_eoi,
    input logic             eoi_bcast
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!irq_pending && ppr_out == '0));

    assert_pend_has_req_R2: assert property (@(posedge clk) disable iff (rst)
        irq_pending |-> cur_irr_found);

    assert_ppr_not_below_tpr_R4: assert property (@(posedge clk) disable iff (rst)
        ppr_out >= tpr_cur);

    assert_ack_answered_R6: assert property (@(posedge clk) disable iff (rst)
        ack_valid |=> ack_rsp_valid);

    assert_answer_has_cause_R6: assert property (@(posedge clk) disable iff (rst)
        ack_rsp_valid |-> $past(ack_valid));

    assert_bcast_cause_R8: assert property (@(posedge clk) disable iff (rst)
        eoi_bcast |-> ($past(eoi_valid) && !$past(directed_eoi)));

    assert_disabled_silent_R10: assert property (@(posedge clk) disable iff (rst)
        !spur_en |-> !irq_pending);
endmodule

bind vic_core vic_core_chk #(.VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst(rst), .irq_pending(irq_pending), .ppr_out(ppr_out),
    .tpr_cur(tpr_cur), .spur_en(spur_en), .cur_irr_found(cur_irr_found),
    .ack_valid(ack_valid), .ack_rsp_valid(ack_rsp_valid), .eoi_valid(eoi_valid),
    .directed_eoi(directed_eoi), .eoi_bcast(eoi_bcast));

// File: tb/sim_vic_core.sv
module sim_vic_core;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [7:0] req_vector = '0;
    logic       req_level = 1'b0;
    logic       tpr_we = 1'b0;
    logic [7:0] tpr_wdata = '0;
    logic       ack_valid = 1'b0;
    logic       eoi_valid = 1'b0;
    logic       spur_we = 1'b0;
    logic [8:0] spur_wdata = '0;
    logic       directed_eoi = 1'b0;
    logic       irq_pending;
    logic [7:0] ppr_out;
    logic       ack_rsp_valid, ack_rsp_none;
    logic [7:0] ack_rsp_vector;
    logic       eoi_bcast;
    logic [7:0] eoi_bcast_vector;

    vic_core u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vector(req_vector),
        .req_level(req_level), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
        .ack_valid(ack_valid), .eoi_valid(eoi_valid), .spur_we(spur_we),
        .spur_wdata(spur_wdata), .directed_eoi(directed_eoi),
        .irq_pending(irq_pending), .ppr_out(ppr_out), .ack_rsp_valid(ack_rsp_valid),
        .ack_rsp_none(ack_rsp_none), .ack_rsp_vector(ack_rsp_vector),
        .eoi_bcast(eoi_bcast), .eoi_bcast_vector(eoi_bcast_vector));

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    // ---------------- behavioural reference model ----------------
    logic [255:0] m_irr, m_isr, m_tmr, ni, ns, nt;
    int  m_tpr, m_spur;
    bit  e_pend, e_rv, e_rn, e_bc, grant;
    int  e_ppr, e_rvec, e_bcv, r, s, p;

    function automatic int hi(logic [255:0] v);
        for (int i = 255; i >= 0; i--) if (v[i]) return i;
        return -1;
    endfunction

    function automatic int ppr_of(int tpr, logic [255:0] isr);
        int sv = hi(isr);
        int sc = (sv < 0) ? 0 : (sv >> 4);
        return ((tpr >> 4) >= sc) ? tpr : (sc << 4);
    endfunction

    function automatic bit deliverable(logic [255:0] irr, logic [255:0] isr, int tpr, int spur);
        int rv = hi(irr);
        int pv = ppr_of(tpr, isr);
        if (spur[8] == 1'b0 || rv < 0) return 1'b0;
        if (pv != 0 && (rv >> 4) <= (pv >> 4)) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = 0; m_spur = 'h0FF;
            e_pend = 0; e_ppr = 0; e_rv = 0; e_rn = 0; e_rvec = 0; e_bc = 0; e_bcv = 0;
        end else begin
            r = hi(m_irr); s = hi(m_isr); p = ppr_of(m_tpr, m_isr);
            ni = m_irr; ns = m_isr; nt = m_tmr;
            grant = 0; e_rv = ack_valid; e_rn = 0; e_rvec = 0;
            if (ack_valid) begin
                if (m_spur[8] == 1'b0 || r < 0) e_rn = 1;
                else if (p != 0 && (r >> 4) <= (p >> 4)) e_rvec = m_spur & 255;
                else begin e_rvec = r; grant = 1; end
            end
            e_bc = 0; e_bcv = 0;
            if (eoi_valid && s >= 0) begin
                ns[s] = 1'b0;
                if (m_tmr[s] && !directed_eoi) begin e_bc = 1; e_bcv = s; end
            end
            if (grant) begin ni[r] = 1'b0; ns[r] = 1'b1; end
            if (req_valid) begin ni[req_vector] = 1'b1; nt[req_vector] = req_level; end
            if (tpr_we)  m_tpr  = int'(tpr_wdata);
            if (spur_we) m_spur = int'(spur_wdata);
            m_irr = ni; m_isr = ns; m_tmr = nt;
            e_ppr  = ppr_of(m_tpr, m_isr);
            e_pend = deliverable(m_irr, m_isr, m_tpr, m_spur);
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 model irq_pending", int'(irq_pending), int'(e_pend));
            chk("R4 model ppr_out", int'(ppr_out), e_ppr);
            chk("R6 model ack_rsp_valid", int'(ack_rsp_valid), int'(e_rv));
            if (e_rv) begin
                chk("R6 model ack_rsp_none", int'(ack_rsp_none), int'(e_rn));
                chk("R5 model ack_rsp_vector", int'(ack_rsp_vector), e_rvec);
            end
            chk("R8 model eoi_bcast", int'(eoi_bcast), int'(e_bc));
            if (e_bc) chk("R8 model eoi_bcast_vector", int'(eoi_bcast_vector), e_bcv);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle_all();
        req_valid = 0; tpr_we = 0; ack_valid = 0; eoi_valid = 0; spur_we = 0;
    endtask

    task automatic do_req(int v, bit lvl);
        @(negedge clk); req_valid = 1; req_vector = 8'(v); req_level = lvl;
        @(negedge clk); idle_all();
    endtask

    task automatic do_ack();
        @(negedge clk); ack_valid = 1;
        @(negedge clk); idle_all();
    endtask

    task automatic do_eoi();
        @(negedge clk); eoi_valid = 1;
        @(negedge clk); idle_all();
    endtask

    task automatic do_tpr(int v);
        @(negedge clk); tpr_we = 1; tpr_wdata = 8'(v);
        @(negedge clk); idle_all();
    endtask

    task automatic do_spur(int v);
        @(negedge clk); spur_we = 1; spur_wdata = 9'(v);
        @(negedge clk); idle_all();
    endtask

    task automatic ack_expect(string tag, bit none, int vec);
        do_ack();
        chk({tag, " rsp_valid"}, int'(ack_rsp_valid), 1);
        chk({tag, " rsp_none"}, int'(ack_rsp_none), int'(none));
        if (!none) chk({tag, " rsp_vector"}, int'(ack_rsp_vector), vec);
    endtask

    initial begin
        #(CLK_P * 190000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pending after reset", int'(irq_pending), 0);
        chk("R1 ppr after reset", int'(ppr_out), 0);
        ack_expect("R1 ack while reset-disabled", 1, 0);

        // R10 disabled controller holds pending low
        do_req('h45, 0);
        chk("R10 pending while disabled", int'(irq_pending), 0);
        do_spur('h13A);
        chk("R2 pending after enable", int'(irq_pending), 1);

        // R3 highest first, R4 ppr from in-service, R5 masked spurious
        do_req('h91, 1);
        do_req('h30, 0);
        ack_expect("R3 highest vector", 0, 'h91);
        chk("R4 ppr from in-service class", int'(ppr_out), 'h90);
        chk("R5 lower classes masked", int'(irq_pending), 0);
        ack_expect("R5 spurious on masked", 0, 'h3A);
        do_tpr('hA5);
        chk("R4 ppr from tpr", int'(ppr_out), 'hA5);
        do_eoi();
        chk("R8 level broadcast", int'(eoi_bcast), 1);
        chk("R8 broadcast vector", int'(eoi_bcast_vector), 'h91);

        // R5 equal-class boundary
        do_tpr('h4F);
        chk("R5 equal class masked", int'(irq_pending), 0);
        do_tpr('h3F);
        chk("R5 higher class delivered", int'(irq_pending), 1);
        do_tpr('h00);
        ack_expect("R6 grant 0x45", 0, 'h45);
        ack_expect("R5 masked by in-service", 0, 'h3A);
        do_eoi();
        chk("R8 edge no broadcast", int'(eoi_bcast), 0);
        chk("R7 ppr after retire", int'(ppr_out), 0);
        ack_expect("R6 grant 0x30", 0, 'h30);
        ack_expect("R6 empty ack", 1, 0);
        chk("R4 ppr in-service 0x30", int'(ppr_out), 'h30);
        do_eoi();
        do_eoi();
        chk("R7 eoi with empty in-service", int'(eoi_bcast), 0);
        chk("R7 ppr stays zero", int'(ppr_out), 0);

        // R7 highest in-service retired first
        do_req('h81, 0);
        ack_expect("R3 grant 0x81", 0, 'h81);
        do_req('hC2, 0);
        ack_expect("R3 grant 0xC2 nested", 0, 'hC2);
        chk("R4 nested ppr", int'(ppr_out), 'hC0);
        do_eoi();
        chk("R7 highest retired", int'(ppr_out), 'h80);
        do_eoi();
        chk("R7 all retired", int'(ppr_out), 0);

        // R9 trigger overwrite
        do_req('h70, 1);
        do_req('h70, 0);
        ack_expect("R9 grant 0x70", 0, 'h70);
        do_eoi();
        chk("R9 edge overwrote level", int'(eoi_bcast), 0);
        do_req('h70, 0);
        do_req('h70, 1);
        ack_expect("R9 grant 0x70 again", 0, 'h70);
        do_eoi();
        chk("R9 level overwrote edge", int'(eoi_bcast), 1);
        chk("R9 broadcast vector", int'(eoi_bcast_vector), 'h70);

        // R8 directed mode
        directed_eoi = 1;
        do_req('h60, 1);
        ack_expect("R8 grant 0x60", 0, 'h60);
        do_eoi();
        chk("R8 directed suppresses", int'(eoi_bcast), 0);
        directed_eoi = 0;

        // R11 same-cycle request and acknowledge
        @(negedge clk); ack_valid = 1; req_valid = 1; req_vector = 'h50; req_level = 0;
        @(negedge clk); idle_all();
        chk("R11 ack sees old empty state", int'(ack_rsp_none), 1);
        chk("R11 request applied", int'(irq_pending), 1);
        @(negedge clk); ack_valid = 1; req_valid = 1; req_vector = 'h50; req_level = 0;
        @(negedge clk); idle_all();
        chk("R11 grant 0x50", int'(ack_rsp_vector), 'h50);
        chk("R11 re-request kept but masked", int'(irq_pending), 0);
        do_eoi();
        chk("R11 re-request visible after retire", int'(irq_pending), 1);
        ack_expect("R11 second grant 0x50", 0, 'h50);
        do_eoi();

        // R10 disable and re-enable
        do_req('h20, 0);
        chk("R10 pending while enabled", int'(irq_pending), 1);
        do_spur('h0FF);
        chk("R10 disable drops pending", int'(irq_pending), 0);
        ack_expect("R10 ack while disabled", 1, 0);
        do_spur('h100);
        chk("R10 re-enable", int'(irq_pending), 1);
        ack_expect("R10 request survived disable", 0, 'h20);
        do_eoi();

        // random phase, compared by the model every cycle
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            req_valid    = ($urandom % 3 == 0);
            req_vector   = 8'($urandom);
            req_level    = 1'($urandom);
            tpr_we       = ($urandom % 16 == 0);
            tpr_wdata    = 8'($urandom % 160);
            ack_valid    = ($urandom % 4 == 0);
            eoi_valid    = ($urandom % 4 == 0);
            spur_we      = ($urandom % 40 == 0);
            spur_wdata   = {($urandom % 8 != 0), 8'($urandom)};
            directed_eoi = ($urandom % 6 == 0);
        end
        @(negedge clk); idle_all(); directed_eoi = 0;
        repeat (3) @(negedge clk);
        done = 1;
        report();
        $finish;
    end
endmodule